// File: doc/BRIEF.md
# Fast System Call Transfer Unit

This block works out the privilege-transfer state for a fast system-call entry and for the matching fast return. It holds four 64-bit configuration words. The first is the selector and legacy target word, which provides the selector bases and the 32-bit legacy entry point. The second and third are the 64-bit and compatibility entry points. The fourth is a flag-clear mask. From these words and the current processor state, the block produces the code and stack selectors, the new privilege level, the new flags, the new instruction pointer and the values to be saved into general registers. It also raises a fault when the transfer is not allowed.

The execution pipeline pulses `req_entry` or `req_return` for one cycle, together with the mode bits, the current flags and the saved return address. The result appears registered on the next cycle, marked by `out_valid`. Loading the segment descriptors and writing the register file are left to the consumer of these outputs.

Top module: `fastcall_xfer`

## Requirements
- R1: Four 64-bit configuration words are addressed by `cfg_addr`: 0 is the selector/legacy target word, 1 is the 64-bit entry target, 2 is the compatibility entry target, 3 is the flag-clear mask. A word is written at a clock edge when `cfg_we` is high. `cfg_rdata` shows the addressed word combinationally. All words are zero after reset. A request in the same cycle as a write uses the old value.
- R2: A request sampled at a clock edge makes `out_valid` high for exactly the following cycle. Without a request, `out_valid` is low.
- R3: When `sce_en` is 0, both an entry and a return give `out_valid` and `out_fault` high. A faulting request leaves `out_cs`, `out_ss`, `out_cpl`, `out_ip`, `out_flags`, `out_link_ip` and `out_link_flags` at their previous values. `out_fault` is never high without `out_valid`.
- R4: On entry, `out_cs` is word0 bits 47:32 with its low two bits forced to 0, `out_ss` is word0 bits 47:32 plus 8 (16-bit wrap), and `out_cpl` is 0.
- R5: On entry with `long_mode`=0, `out_ip` is word0 bits 31:0, zero-extended. `out_flags` is `cur_flags` with bit 9 (interrupt enable), bit 16 (resume) and bit 17 (virtual-8086) cleared. `out_link_ip` is `saved_ret` bits 31:0, zero-extended. `out_link_flags` is 0.
- R6: On entry with `long_mode`=1, `out_ip` is word1 when `sub64`=1 and word2 when `sub64`=0. `out_flags` is `cur_flags` with every bit that is set in word3 cleared, and with bit 16 also cleared. `out_link_ip` is `saved_ret` and `out_link_flags` is `cur_flags` unchanged.
- R7: With `sce_en`=1, a return faults when `real_mode` is 1 or `cpl_in` is not 0.
- R8: On a successful return, let B be word0 bits 63:48. With `op64`=1, `out_cs` is (B+16) OR 3; with `op64`=0, it is B OR 3. In both cases `out_ss` is B+8 and `out_cpl` is 3. All sums wrap at 16 bits.
- R9: On a successful return with `op64`=1, `out_ip` is `saved_ret` and `out_flags` is `saved_flags`. With `op64`=0, `out_ip` is `saved_ret` bits 31:0, zero-extended, and `out_flags` is `cur_flags` with bit 9 set. `out_link_ip` and `out_link_flags` are 0.
- R10: When `req_entry` and `req_return` are both high, the entry is performed and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word index |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Addressed configuration word |
| req_entry | input | 1 | One-cycle system-call entry request |
| req_return | input | 1 | One-cycle system-call return request |
| sce_en | input | 1 | Fast system call enable |
| long_mode | input | 1 | Long mode active |
| sub64 | input | 1 | 64-bit submode (vs compatibility) |
| cpl_in | input | 2 | Current privilege level |
| op64 | input | 1 | Return targets 64-bit mode |
| real_mode | input | 1 | Real mode active |
| cur_flags | input | 64 | Current flags |
| saved_flags | input | 64 | Flags saved in a general register (for return) |
| saved_ret | input | 64 | Return address (next IP on entry, saved IP on return) |
| out_valid | output | 1 | Result valid |
| out_fault | output | 1 | Request faulted |
| out_cs | output | 16 | New code selector |
| out_ss | output | 16 | New stack selector |
| out_cpl | output | 2 | New privilege level |
| out_ip | output | 64 | New instruction pointer |
| out_flags | output | 64 | New flags |
| out_link_ip | output | 64 | Return address to save in a general register |
| out_link_flags | output | 64 | Flags to save in a general register |

## Verification
Every result of a request is due in the cycle after the edge that samples it. The outputs then hold until the next successful request. `cfg_rdata` follows the address and any write within the same cycle. The bench keeps a behavioural model that is updated at each rising edge from the inputs held stable over that edge. It compares every output at the falling edge, so each expectation is checked exactly one register stage after its stimulus. The same comparison confirms, on the cycles that follow, that values are held after faults and after idle cycles.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int XLEN    = 64;
  localparam int SEL_W   = 16;
  localparam int NREGS   = 4;
  localparam int ADDR_W  = $clog2(NREGS);
  localparam int HALF_W  = XLEN / 2;
  // selector fields inside configuration word 0
  localparam int ENT_LO  = 32;
  localparam int RET_LO  = 48;
  // flag bit positions
  localparam int IF_BIT  = 9;
  localparam int RF_BIT  = 16;
  localparam int VM_BIT  = 17;
  localparam logic [1:0] RPL_USER = 2'b11;

  typedef enum logic [ADDR_W-1:0] {
    W_SEL  = 2'd0,
    W_LTGT = 2'd1,
    W_CTGT = 2'd2,
    W_MASK = 2'd3
  } cfg_idx_e;

  typedef struct packed {
    logic             fault;
    logic [SEL_W-1:0] cs;
    logic [SEL_W-1:0] ss;
    logic [1:0]       cpl;
    logic [XLEN-1:0]  ip;
    logic [XLEN-1:0]  flags;
    logic [XLEN-1:0]  link_ip;
    logic [XLEN-1:0]  link_flags;
  } xfer_res_t;
endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
  import fsc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [XLEN-1:0]             wdata,
  output logic [XLEN-1:0]             rdata,
  output logic [NREGS-1:0][XLEN-1:0]  words
);
  logic [NREGS-1:0] wr_en;

  for (genvar g = 0; g < NREGS; g++) begin : g_word
    logic [XLEN-1:0] word_d;
    assign wr_en[g] = we && (addr == ADDR_W'(g));

    always_comb begin
      word_d = words[g];
      if (wr_en[g]) word_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (wr_en[g]) words[g] <= word_d;
    end
  end

  assign rdata = words[addr];

  // R1
  one_word_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
endmodule

// File: rtl/fsc_entry_calc.sv
module fsc_entry_calc
  import fsc_pkg::*;
(
  input  logic                sce_en,
  input  logic                long_mode,
  input  logic                sub64,
  input  logic [RET_LO-1:0]   sel_word,
  input  logic [XLEN-1:0]     long_tgt,
  input  logic [XLEN-1:0]     compat_tgt,
  input  logic [XLEN-1:0]     clr_mask,
  input  logic [XLEN-1:0]     cur_flags,
  input  logic [XLEN-1:0]     saved_ret,
  output xfer_res_t           res
);
  logic [SEL_W-1:0] base;
  assign base = sel_word[ENT_LO +: SEL_W];

  always_comb begin
    res       = '0;
    res.fault = !sce_en;
    res.cs    = {base[SEL_W-1:2], 2'b00};
    res.ss    = base + SEL_W'(8);
    res.cpl   = 2'd0;
    if (long_mode) begin
      res.ip             = sub64 ? long_tgt : compat_tgt;
      res.flags          = cur_flags & ~clr_mask;
      res.flags[RF_BIT]  = 1'b0;
      res.link_ip        = saved_ret;
      res.link_flags     = cur_flags;
    end else begin
      res.ip             = {{(XLEN-HALF_W){1'b0}}, sel_word[HALF_W-1:0]};
      res.flags          = cur_flags;
      res.flags[IF_BIT]  = 1'b0;
      res.flags[RF_BIT]  = 1'b0;
      res.flags[VM_BIT]  = 1'b0;
      res.link_ip        = {{(XLEN-HALF_W){1'b0}}, saved_ret[HALF_W-1:0]};
      res.link_flags     = '0;
    end
  end
endmodule

// File: rtl/fsc_return_calc.sv
module fsc_return_calc
  import fsc_pkg::*;
(
  input  logic               sce_en,
  input  logic               real_mode,
  input  logic [1:0]         cpl_in,
  input  logic               op64,
  input  logic [SEL_W-1:0]   ret_base,
  input  logic [XLEN-1:0]    cur_flags,
  input  logic [XLEN-1:0]    saved_flags,
  input  logic [XLEN-1:0]    saved_ret,
  output xfer_res_t          res
);
  always_comb begin
    res       = '0;
    res.fault = !sce_en || real_mode || (cpl_in != 2'd0);
    res.ss    = ret_base + SEL_W'(8);
    res.cpl   = RPL_USER;
    if (op64) begin
      res.cs    = (ret_base + SEL_W'(16)) | SEL_W'(RPL_USER);
      res.ip    = saved_ret;
      res.flags = saved_flags;
    end else begin
      res.cs            = ret_base | SEL_W'(RPL_USER);
      res.ip            = {{(XLEN-HALF_W){1'b0}}, saved_ret[HALF_W-1:0]};
      res.flags         = cur_flags;
      res.flags[IF_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/fastcall_xfer.sv
module fastcall_xfer
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [XLEN-1:0]   cfg_wdata,
  output logic [XLEN-1:0]   cfg_rdata,
  input  logic              req_entry,
  input  logic              req_return,
  input  logic              sce_en,
  input  logic              long_mode,
  input  logic              sub64,
  input  logic [1:0]        cpl_in,
  input  logic              op64,
  input  logic              real_mode,
  input  logic [XLEN-1:0]   cur_flags,
  input  logic [XLEN-1:0]   saved_flags,
  input  logic [XLEN-1:0]   saved_ret,
  output logic              out_valid,
  output logic              out_fault,
  output logic [SEL_W-1:0]  out_cs,
  output logic [SEL_W-1:0]  out_ss,
  output logic [1:0]        out_cpl,
  output logic [XLEN-1:0]   out_ip,
  output logic [XLEN-1:0]   out_flags,
  output logic [XLEN-1:0]   out_link_ip,
  output logic [XLEN-1:0]   out_link_flags
);
  logic [NREGS-1:0][XLEN-1:0] words;
  xfer_res_t ent_res, ret_res, sel_res, res_q, res_d;
  logic      req_any, load_en, valid_d, fault_d;

  fsc_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .words (words)
  );

  fsc_entry_calc u_ent (
    .sce_en     (sce_en),
    .long_mode  (long_mode),
    .sub64      (sub64),
    .sel_word   (words[W_SEL][RET_LO-1:0]),
    .long_tgt   (words[W_LTGT]),
    .compat_tgt (words[W_CTGT]),
    .clr_mask   (words[W_MASK]),
    .cur_flags  (cur_flags),
    .saved_ret  (saved_ret),
    .res        (ent_res)
  );

  fsc_return_calc u_ret (
    .sce_en      (sce_en),
    .real_mode   (real_mode),
    .cpl_in      (cpl_in),
    .op64        (op64),
    .ret_base    (words[W_SEL][RET_LO +: SEL_W]),
    .cur_flags   (cur_flags),
    .saved_flags (saved_flags),
    .saved_ret   (saved_ret),
    .res         (ret_res)
  );

  // next-state: entry takes precedence over return
  always_comb begin
    req_any = req_entry || req_return;
    sel_res = req_entry ? ent_res : ret_res;
    valid_d = req_any;
    fault_d = req_any && sel_res.fault;
    load_en = req_any && !sel_res.fault;
    res_d   = res_q;
    if (load_en) res_d = sel_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else if (load_en) res_q <= res_d;
  end

  assign out_cs         = res_q.cs;
  assign out_ss         = res_q.ss;
  assign out_cpl        = res_q.cpl;
  assign out_ip         = res_q.ip;
  assign out_flags      = res_q.flags;
  assign out_link_ip    = res_q.link_ip;
  assign out_link_flags = res_q.link_flags;

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_entry || req_return) |=> out_valid);
  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_entry || req_return) |=> !out_valid);
  // R3
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> out_valid);
  // R3
  fault_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fault |-> ($stable(out_cs) && $stable(out_ip) && $stable(out_flags)
                   && $stable(out_cpl) && $stable(out_link_ip)));
  // R4
  entry_kernel_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_entry && sce_en) |=> (!out_fault && out_cpl == 2'd0 && out_cs[1:0] == 2'b00));
  // R7
  return_priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_return && !req_entry && (cpl_in != 2'd0 || real_mode)) |=> out_fault);
  // R8
  return_user_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_return && !req_entry && sce_en && !real_mode && cpl_in == 2'd0)
      |=> (out_cpl == 2'd3 && out_cs[1:0] == 2'b11));
endmodule

// File: tb/fastcall_xfer_tb.sv
module fastcall_xfer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [63:0] cfg_wdata, cfg_rdata;
  logic        req_entry, req_return, sce_en, long_mode, sub64, op64, real_mode;
  logic [1:0]  cpl_in;
  logic [63:0] cur_flags, saved_flags, saved_ret;
  logic        out_valid, out_fault;
  logic [15:0] out_cs, out_ss;
  logic [1:0]  out_cpl;
  logic [63:0] out_ip, out_flags, out_link_ip, out_link_flags;

  fastcall_xfer u_dut (.*);

  int checks = 0;
  int errors = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [63:0] m_reg [4];
  logic        e_valid, e_fault;
  logic [15:0] e_cs, e_ss, h;
  logic [1:0]  e_cpl;
  logic [63:0] e_ip, e_flags, e_lip, e_lfl;
  string       t_flt, t_sel, t_dat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 64'd0;
      e_valid = 0; e_fault = 0; e_cs = 0; e_ss = 0; e_cpl = 0;
      e_ip = 0; e_flags = 0; e_lip = 0; e_lfl = 0;
      t_flt = "R3 reset"; t_sel = "R1 reset"; t_dat = "R1 reset";
    end else begin
      e_valid = req_entry || req_return;
      e_fault = 1'b0;
      if (req_entry) begin
        if (!sce_en) begin
          e_fault = 1'b1; t_flt = "R3 entry disabled"; t_sel = "R3 hold"; t_dat = "R3 hold";
        end else begin
          t_flt = "R3 entry enabled"; t_sel = "R4 entry selectors";
          h = 16'(m_reg[0] >> 32);
          e_cs = h & 16'hFFFC; e_ss = h + 16'd8; e_cpl = 2'd0;
          if (long_mode) begin
            t_dat = "R6 long entry";
            e_ip = sub64 ? m_reg[1] : m_reg[2];
            e_flags = cur_flags & ~m_reg[3] & ~64'h1_0000;
            e_lip = saved_ret; e_lfl = cur_flags;
          end else begin
            t_dat = "R5 legacy entry";
            e_ip = m_reg[0] & 64'hFFFF_FFFF;
            e_flags = cur_flags & ~64'h3_0200;
            e_lip = saved_ret & 64'hFFFF_FFFF; e_lfl = 64'd0;
          end
        end
        if (req_return) begin
          t_flt = {"R10 ", t_flt}; t_sel = {"R10 ", t_sel}; t_dat = {"R10 ", t_dat};
        end
      end else if (req_return) begin
        if (!sce_en) begin
          e_fault = 1'b1; t_flt = "R3 return disabled"; t_sel = "R3 hold"; t_dat = "R3 hold";
        end else if (real_mode || cpl_in != 2'd0) begin
          e_fault = 1'b1; t_flt = "R7 return refused"; t_sel = "R7 hold"; t_dat = "R7 hold";
        end else begin
          t_flt = "R7 return allowed"; t_sel = "R8 return selectors"; t_dat = "R9 return state";
          h = 16'(m_reg[0] >> 48);
          e_cs = op64 ? ((h + 16'd16) | 16'd3) : (h | 16'd3);
          e_ss = h + 16'd8; e_cpl = 2'd3;
          e_ip = op64 ? saved_ret : (saved_ret & 64'hFFFF_FFFF);
          e_flags = op64 ? saved_flags : (cur_flags | 64'h200);
          e_lip = 64'd0; e_lfl = 64'd0;
        end
      end
      if (cfg_we) m_reg[cfg_addr] = cfg_wdata;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag,
                     input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(64'(out_valid), 64'(e_valid), "R2", "valid");
      chk(64'(out_fault), 64'(e_fault), t_flt, "fault");
      chk(64'(out_cs), 64'(e_cs), t_sel, "cs");
      chk(64'(out_ss), 64'(e_ss), t_sel, "ss");
      chk(64'(out_cpl), 64'(e_cpl), t_sel, "cpl");
      chk(out_ip, e_ip, t_dat, "ip");
      chk(out_flags, e_flags, t_dat, "flags");
      chk(out_link_ip, e_lip, t_dat, "link_ip");
      chk(out_link_flags, e_lfl, t_dat, "link_flags");
      chk(cfg_rdata, m_reg[cfg_addr], "R1", "rdata");
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; step(); cfg_we = 0;
  endtask

  task automatic rq(input logic ent, input logic ret, input logic en, input logic lm,
                    input logic s64, input logic [1:0] cpl, input logic o64, input logic rm);
    req_entry = ent; req_return = ret; sce_en = en; long_mode = lm; sub64 = s64;
    cpl_in = cpl; op64 = o64; real_mode = rm;
    step();
    req_entry = 0; req_return = 0;
    step();
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_entry = 0; req_return = 0; sce_en = 0; long_mode = 0; sub64 = 0;
    cpl_in = 0; op64 = 0; real_mode = 0;
    cur_flags = 64'h0000_0000_0003_0EC7; saved_flags = 64'h0000_0000_0000_0A46;
    saved_ret = 64'hFFFF_8000_1234_5678;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    step();
    // R1 configuration and readback
    wr(2'd0, 64'h0028_0013_C000_4000);
    wr(2'd1, 64'hFFFF_8000_0010_0000);
    wr(2'd2, 64'h0000_0000_0040_1000);
    wr(2'd3, 64'h0000_0000_0004_0700);
    for (int a = 0; a < 4; a++) begin cfg_addr = 2'(a); step(); end
    // R3 disabled
    rq(1, 0, 0, 1, 1, 0, 0, 0);
    rq(0, 1, 0, 0, 0, 0, 1, 0);
    // R4 R5 R6 entries
    rq(1, 0, 1, 0, 0, 3, 0, 0);
    rq(1, 0, 1, 1, 1, 3, 0, 0);
    rq(1, 0, 1, 1, 0, 3, 0, 0);
    // R7 refused returns
    rq(0, 1, 1, 1, 1, 3, 1, 0);
    rq(0, 1, 1, 0, 0, 0, 0, 1);
    // R8 R9 returns
    rq(0, 1, 1, 1, 1, 0, 1, 0);
    rq(0, 1, 1, 1, 0, 0, 0, 0);
    // R10 both
    rq(1, 1, 1, 1, 1, 0, 1, 0);
    // wrap boundary of selector sums
    wr(2'd0, 64'hFFF8_FFFE_8765_4321);
    rq(1, 0, 1, 0, 0, 0, 0, 0);
    rq(0, 1, 1, 1, 1, 0, 1, 0);
    rq(0, 1, 1, 1, 1, 0, 0, 0);
    // back-to-back requests
    req_entry = 1; sce_en = 1; long_mode = 1; sub64 = 1; step();
    req_entry = 0; req_return = 1; cpl_in = 0; op64 = 1; step();
    req_return = 0; step();
    // mixed traffic including writes in the request cycle
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      req_entry = r[0] & r[1]; req_return = r[2] & r[3]; sce_en = r[4] | r[5];
      long_mode = r[6]; sub64 = r[7]; cpl_in = r[9:8] & {r[10], r[10]};
      op64 = r[11]; real_mode = r[12] & r[13] & r[14];
      cfg_we = r[15] & r[16] & r[17]; cfg_addr = r[19:18];
      cfg_wdata = {$urandom, $urandom};
      cur_flags = {$urandom, $urandom}; saved_flags = {$urandom, $urandom};
      saved_ret = {$urandom, $urandom};
      step();
    end
    req_entry = 0; req_return = 0; cfg_we = 0;
    repeat (3) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule